// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block qualifies bus cycles for one hardware breakpoint channel. A 16-bit control register selects three qualifiers: what kind of access the cycle is (instruction fetch or operand), which way data moves (read or write), and how wide the access is (byte, word, longword or quadword). Software writes and reads the register over a plain single-register interface.

Each qualifier field has a code meaning "don't compare", which always matches. Each field also has a code that accepts either alternative. The block watches a processor bus that presents a valid strobe, a fetch/operand flag, a write flag and a 2-bit size. When a valid cycle meets every enabled qualifier, and at least one qualifier is enabled, the block raises a break request for exactly one clock. That clock is the one after the cycle. Size codes outside the defined set are kept as written, but they never produce a match.

A register write and a bus cycle in the same clock are judged against the value held before the write.

Top module: `brk_cycle_match`

## Requirements
- R1: Register bits 15:7 always read as 0, whatever value was written to them.
- R2: Bits 6:0 reset to 0. A write stores bits 6:0 exactly, including prohibited size codes, and the stored value is visible on reg_rdata_o in the clock after the write edge.
- R3: The access-type field is at bits 5:4. 00 means don't compare, 01 matches cycles with bus_fetch_i=1, 10 matches cycles with bus_fetch_i=0, and 11 matches both.
- R4: The direction field is at bits 3:2. 00 means don't compare, 01 matches reads (bus_write_i=0), 10 matches writes (bus_write_i=1), and 11 matches both.
- R5: The size code is {bit 6, bits 1:0}. 000 means don't compare, and codes 001, 010, 011 and 100 match bus_size_i values 00 (byte), 01 (word), 10 (longword) and 11 (quadword) respectively.
- R6: Size codes 101, 110 and 111 never produce a break request, whatever the other fields and the bus cycle are.
- R7: No break request is raised when bus_valid_i is low, or when all of bits 6:0 are zero.
- R8: brk_req_o goes high in the clock after a matching valid cycle and stays high for one clock per cycle. Back-to-back matching cycles give back-to-back pulses.
- R9: A field set to its don't-compare code places no constraint on the cycle. A break is requested exactly when every nonzero field matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| bus_valid_i | input | 1 | Bus cycle valid |
| bus_fetch_i | input | 1 | 1 = instruction fetch, 0 = operand access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | 00 byte, 01 word, 10 longword, 11 quadword |
| brk_req_o | output | 1 | Break request pulse |

## Verification
Both results are due exactly one register stage after their stimulus. A write is visible on reg_rdata_o just after the clock edge that takes it, and a bus cycle decides brk_req_o at the edge that ends it. The bench drives every input on the falling edge, waits for the next rising edge, and samples 1 ns later. Each check therefore lands in the first cycle where the new value is due, and before the following stimulus can change it. The back-to-back test holds valid high across consecutive edges and samples after each one. This shows that each pulse belongs to its own cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int CFG_W  = 7;
  localparam int SIZE_W = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_QUAD = 2'b11
  } bus_size_e;

  typedef struct packed {
    logic [2:0] size;
    logic [1:0] kind;
    logic [1:0] dir;
  } brk_cfg_t;
endpackage

// File: rtl/brk_cfg_reg.sv
module brk_cfg_reg
  import brk_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output brk_cfg_t         cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  brk_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.size <= {wdata_i[6], wdata_i[1:0]};
      cfg_q.kind <= wdata_i[5:4];
      cfg_q.dir  <= wdata_i[3:2];
    end
  end

  // reserved upper bits are hard zero
  always_comb begin
    rdata_o      = '0;
    rdata_o[6]   = cfg_q.size[2];
    rdata_o[5:4] = cfg_q.kind;
    rdata_o[3:2] = cfg_q.dir;
    rdata_o[1:0] = cfg_q.size[1:0];
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/brk_sel_match.sv
// two-alternative qualifier: 00 off, 01 first, 10 second, 11 either
module brk_sel_match (
  input  logic [1:0] sel_i,
  input  logic       is_first_i,
  output logic       ok_o
);
  assign ok_o = (sel_i == 2'b00)
              | (sel_i[0] &  is_first_i)
              | (sel_i[1] & ~is_first_i);
endmodule

// File: rtl/brk_size_match.sv
module brk_size_match
  import brk_pkg::*;
(
  input  logic [2:0]        code_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              ok_o
);
  logic [2:0] want;

  always_comb begin
    want = code_i - 3'd1;
    unique case (code_i)
      3'd0:                   ok_o = 1'b1;
      3'd1, 3'd2, 3'd3, 3'd4: ok_o = (want[SIZE_W-1:0] == size_i);
      default:                ok_o = 1'b0;  // prohibited codes
    endcase
  end
endmodule

// File: rtl/brk_cycle_match.sv
module brk_cycle_match
  import brk_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             bus_valid_i,
  input  logic             bus_fetch_i,
  input  logic             bus_write_i,
  input  logic [1:0]       bus_size_i,
  output logic             brk_req_o
);
  brk_cfg_t cfg;
  logic     kind_ok, dir_ok, size_ok, any_en, hit;

  brk_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (reg_rdata_o)
  );

  brk_sel_match u_kind (
    .sel_i      (cfg.kind),
    .is_first_i (bus_fetch_i),
    .ok_o       (kind_ok)
  );

  brk_sel_match u_dir (
    .sel_i      (cfg.dir),
    .is_first_i (~bus_write_i),
    .ok_o       (dir_ok)
  );

  brk_size_match u_size (
    .code_i (cfg.size),
    .size_i (bus_size_i),
    .ok_o   (size_ok)
  );

  assign any_en = |cfg;
  assign hit    = bus_valid_i & any_en & kind_ok & dir_ok & size_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_req_o <= 1'b0;
    else         brk_req_o <= hit;
  end
endmodule

// File: rtl/brk_cycle_match_chk.sv
module brk_cycle_match_chk #(
  parameter int REG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             bus_valid_i,
  input logic             bus_fetch_i,
  input logic             bus_write_i,
  input logic [1:0]       bus_size_i,
  input logic             brk_req_o
);
  logic [2:0] sz_code;
  assign sz_code = {reg_rdata_o[6], reg_rdata_o[1:0]};

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:7] == '0); // R1

  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[6:0] == $past(reg_wdata_i[6:0])); // R2

  AST_PROHIB_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sz_code > 3'd4 && !reg_we_i) |=> !brk_req_o); // R6

  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_valid_i || reg_rdata_o[6:0] == 7'd0) |=> !brk_req_o); // R7

  AST_REQ_FROM_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> $past(bus_valid_i)); // R8

  AST_TYPE_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && reg_rdata_o[5:4] == 2'b01 && !bus_fetch_i) |=> !brk_req_o); // R3

  AST_DIR_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && reg_rdata_o[3:2] == 2'b10 && !bus_write_i) |=> !brk_req_o); // R4
endmodule

bind brk_cycle_match brk_cycle_match_chk #(.REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .bus_valid_i (bus_valid_i),
  .bus_fetch_i (bus_fetch_i),
  .bus_write_i (bus_write_i),
  .bus_size_i  (bus_size_i),
  .brk_req_o   (brk_req_o)
);

// File: tb/sim_brk_cycle_match.sv
`timescale 1ns/1ps
module sim_brk_cycle_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        valid = 1'b0, fetch = 1'b0, wr = 1'b0;
  logic [1:0]  sz = '0;
  logic        brk;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  brk_cycle_match u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .bus_valid_i(valid), .bus_fetch_i(fetch),
    .bus_write_i(wr), .bus_size_i(sz), .brk_req_o(brk)
  );

  function automatic logic [15:0] mk(logic [2:0] s, logic [1:0] k, logic [1:0] d);
    return {9'd0, s[2], k, d, s[1:0]};
  endfunction

  function automatic logic model(logic [15:0] r, logic f, logic w, logic [1:0] z);
    logic [1:0] k = r[5:4];
    logic [1:0] d = r[3:2];
    logic [2:0] s = {r[6], r[1:0]};
    logic k_ok = (k == 0) || (k == 1 && f) || (k == 2 && !f) || (k == 3);
    logic d_ok = (d == 0) || (d == 1 && !w) || (d == 2 && w) || (d == 3);
    logic s_ok = (s == 0) || (s >= 1 && s <= 4 && {1'b0, z} == s - 3'd1);
    return (r[6:0] != 0) && k_ok && d_ok && s_ok;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [15:0] v);
    @(negedge clk); valid = 0; we = 1; wdata = v;
    @(posedge clk); #1;
    @(negedge clk); we = 0;
  endtask

  // drive one bus cycle, sample the pulse one edge later
  task automatic cyc(string req, logic f, logic w, logic [1:0] z, logic exp);
    @(negedge clk); valid = 1; fetch = f; wr = w; sz = z;
    @(posedge clk); #1;
    chk(req, {15'd0, brk}, {15'd0, exp});
  endtask

  task automatic idle(string req);
    @(negedge clk); valid = 0;
    @(posedge clk); #1;
    chk(req, {15'd0, brk}, 16'd0);
  endtask

  task automatic t_reset;
    chk("R2 reset", rdata, 16'h0000);
    chk("R7 reset", {15'd0, brk}, 16'd0);
  endtask

  task automatic t_reserved;
    wreg(16'hFFFF); chk("R1", rdata, 16'h007F);
    wreg(16'hFF80); chk("R1", rdata, 16'h0000);
    wreg(16'h0035); chk("R2", rdata, 16'h0035);
  endtask

  task automatic t_kind;
    wreg(mk(3'd0, 2'b01, 2'b00));
    cyc("R3 fetch", 1, 0, 2'd0, 1); cyc("R3 operand", 0, 0, 2'd0, 0);
    wreg(mk(3'd0, 2'b10, 2'b00));
    cyc("R3 fetch", 1, 1, 2'd1, 0); cyc("R3 operand", 0, 1, 2'd1, 1);
    wreg(mk(3'd0, 2'b11, 2'b00));
    cyc("R3 either", 1, 0, 2'd2, 1); cyc("R3 either", 0, 1, 2'd3, 1);
    idle("R3");
  endtask

  task automatic t_dir;
    wreg(mk(3'd0, 2'b00, 2'b01));
    cyc("R4 read", 0, 0, 2'd0, 1); cyc("R4 read", 1, 1, 2'd0, 0);
    wreg(mk(3'd0, 2'b00, 2'b10));
    cyc("R4 write", 0, 1, 2'd0, 1); cyc("R4 write", 1, 0, 2'd0, 0);
    wreg(mk(3'd0, 2'b00, 2'b11));
    cyc("R4 either", 0, 0, 2'd1, 1); cyc("R4 either", 1, 1, 2'd1, 1);
    idle("R4");
  endtask

  task automatic t_size;
    for (int c = 1; c <= 4; c++) begin
      wreg(mk(3'(c), 2'b00, 2'b00));
      for (int z = 0; z < 4; z++)
        cyc("R5", 0, 0, 2'(z), (z == c - 1));
    end
    idle("R5");
  endtask

  task automatic t_prohib;
    for (int c = 5; c <= 7; c++) begin
      wreg(mk(3'(c), 2'b11, 2'b11));
      chk("R6 readback", rdata, mk(3'(c), 2'b11, 2'b11));
      for (int z = 0; z < 4; z++)
        cyc("R6", z[0], z[1], 2'(z), 0);
    end
    idle("R6");
  endtask

  task automatic t_off;
    wreg(16'h0000);
    for (int z = 0; z < 8; z++) cyc("R7 all off", z[0], z[1], 2'(z), 0);
    wreg(mk(3'd0, 2'b11, 2'b11));
    @(negedge clk); valid = 0; fetch = 1; wr = 1;
    @(posedge clk); #1; chk("R7 invalid", {15'd0, brk}, 16'd0);
  endtask

  task automatic t_b2b;
    wreg(mk(3'd3, 2'b10, 2'b01));
    cyc("R8 first", 0, 0, 2'd2, 1);
    cyc("R8 second", 0, 0, 2'd2, 1);
    cyc("R8 miss", 1, 0, 2'd2, 0);
    cyc("R8 third", 0, 0, 2'd2, 1);
    idle("R8 drop");
  endtask

  task automatic t_sweep;
    for (int r = 0; r < 128; r++) begin
      wreg(16'(r));
      for (int b = 0; b < 16; b++)
        cyc("R9 sweep", b[0], b[1], b[3:2], model(16'(r), b[0], b[1], b[3:2]));
    end
    idle("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    t_reserved();
    t_kind();
    t_dir();
    t_size();
    t_prohib();
    t_off();
    t_b2b();
    t_sweep();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule